// File: doc/BRIEF.md
# Modulo Timer with Interlocked Overflow Flag

This block is an up-counter that advances on prescaled ticks of its clock and wraps to zero at a programmable modulo value. Software controls it through a small synchronous register bus made of an address, a read strobe, a write strobe, write data and combinational read data. One 8-bit control/status register holds the overflow flag, the overflow interrupt enable, a halt bit, a write-only counter clear and a 3-bit prescaler select. Two further byte registers hold the modulo value, and two read-only byte addresses return the current count.

The overflow flag can be cleared only by a read that sees the flag set, followed by a write of 0 to the flag bit. An overflow between those two accesses cancels the clear, so a pending interrupt is never dropped. The halt bit comes out of reset set, so the counter does not move until software starts it. The halt bit also drives an output that inhibits capture logic outside this block.

Top module: `modtmr_ctl`

## Requirements
- R1: After reset the control register (address 0) reads 0x20, the count is 0, the modulo value is all ones, `irq_o` is 0 and `cap_inhibit_o` is 1.
- R2: Control register layout is bit 7 overflow flag, bit 6 interrupt enable, bit 5 halt, bit 4 counter clear, bits 2:0 prescaler select. Bit 4 and bit 3 always read 0, and writing 1 to bit 3 stores nothing.
- R3: While running, the counter advances once every 2^sel clock cycles for select values 0 to 6, and once every 64 cycles for select value 7. Counted from the edge of a counter-clear write, after t edges the count equals floor(t/div) mod (modulo+1).
- R4: On a tick where the count equals the modulo value, the count wraps to 0 and the overflow flag sets on that same edge. A modulo of 0 overflows on every tick.
- R5: The overflow flag clears only when a control-register write with bit 7 = 0 follows a control-register read that saw the flag at 1. A write of 0 without such a read leaves the flag set.
- R6: If an overflow occurs after the arming read and before the clearing write, that write leaves the flag set.
- R7: Writing 1 to bit 7 never sets the flag.
- R8: `irq_o` is 1 exactly when both the overflow flag and the interrupt enable are 1.
- R9: While the halt bit is 1, the count holds its value and `cap_inhibit_o` is 1. After the halt bit is cleared, counting resumes from the held value.
- R10: Writing 1 to bit 4 sets the count and the prescaler phase to 0 on that edge. All other control bits take the written data as in any control write.
- R11: Address 1 and address 2 hold the low and high bytes of the modulo value, and both read back. Address 3 and address 4 return the low and high bytes of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_addr_i | input | 3 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Overflow interrupt request |
| cap_inhibit_o | output | 1 | Capture inhibit, follows the halt bit |
| count_o | output | CNT_W | Current count |
| modulo_o | output | CNT_W | Programmed modulo value |

## Verification
Register writes, the clear bit and overflows all take effect on the clock edge that ends the write or tick cycle. Read data is combinational, so a result appears half a cycle after the edge that produced it. The bench drives every access at a falling edge and samples 1 ns later, so each sample falls after exactly t rising edges since a counter-clear write. Each expected count and flag is computed as floor(t/div) mod (modulo+1), and the flag is expected once t/div exceeds the modulo. The interlock sequences are stepped edge by edge: the overflow edge is placed between the arming read and the clearing write, and the flag is checked at the next falling edge.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MODLO = 3'd1;
   localparam logic [ADDR_W-1:0] A_MODHI = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNTLO = 3'd3;
   localparam logic [ADDR_W-1:0] A_CNTHI = 3'd4;

   localparam int unsigned B_FLAG = 7;
   localparam int unsigned B_IE   = 6;
   localparam int unsigned B_HALT = 5;
   localparam int unsigned B_CLR  = 4;

   localparam logic [DATA_W-1:0] CTRL_RST = 8'h20;
endpackage

// File: rtl/modtmr_presc.sv
module modtmr_presc #(
   parameter int unsigned MAX_SHIFT = 6
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       run_i,
   input  logic       clr_i,
   input  logic [2:0] sel_i,
   output logic       tick_o
);
   localparam int unsigned PW = MAX_SHIFT;

   logic [PW-1:0] phase_q;
   logic [2:0]    shift;
   logic [PW:0]   full;
   logic [PW-1:0] mask;

   always_comb begin
      shift = (sel_i > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : sel_i;
      full  = (PW+1)'(1) << shift;
      mask  = PW'(full - 1'b1);
   end

   assign tick_o = run_i && ((phase_q & mask) == mask);

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         phase_q <= '0;
      end else if (run_i) begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] mod_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap_o = tick_i && !clr_i && (cnt_q == mod_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
   import modtmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wrap_i,
   output logic              flag_o,
   output logic              ie_o,
   output logic              halt_o,
   output logic [2:0]        sel_o,
   output logic              clr_o,
   output logic [CNT_W-1:0]  mod_o
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   logic ctrl_wr, ctrl_rd;
   logic flag_q, arm_q, ie_q, halt_q;
   logic [2:0] sel_q;
   logic [CNT_W-1:0] mod_q;

   assign ctrl_wr = wr_i && (addr_i == A_CTRL);
   assign ctrl_rd = rd_i && (addr_i == A_CTRL);
   assign clr_o   = ctrl_wr && wdata_i[B_CLR];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (wrap_i)
            flag_q <= 1'b1;
         else if (ctrl_wr && !wdata_i[B_FLAG] && arm_q)
            flag_q <= 1'b0;

         if (wrap_i || ctrl_wr)
            arm_q <= 1'b0;
         else if (ctrl_rd && flag_q)
            arm_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ie_q   <= CTRL_RST[B_IE];
         halt_q <= CTRL_RST[B_HALT];
         sel_q  <= CTRL_RST[2:0];
      end else if (ctrl_wr) begin
         ie_q   <= wdata_i[B_IE];
         halt_q <= wdata_i[B_HALT];
         sel_q  <= wdata_i[2:0];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mod_q <= '1;
      end else if (wr_i) begin
         if (addr_i == A_MODLO) mod_q[DATA_W-1:0]     <= wdata_i;
         if (addr_i == A_MODHI) mod_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
      end
   end

   assign flag_o = flag_q;
   assign ie_o   = ie_q;
   assign halt_o = halt_q;
   assign sel_o  = sel_q;
   assign mod_o  = mod_q;
endmodule

// File: rtl/modtmr_ctl.sv
module modtmr_ctl
   import modtmr_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned MAX_SHIFT = 6
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [2:0]        bus_addr_i,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   output logic              irq_o,
   output logic              cap_inhibit_o,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  modulo_o
);
   localparam int unsigned WIDE = 2 * DATA_W;

   generate
      if (CNT_W <= DATA_W || CNT_W > WIDE) begin : g_bad_cnt_w
         $error("modtmr_ctl: CNT_W must lie in 9..16");
      end
      if (MAX_SHIFT < 1 || MAX_SHIFT > 7) begin : g_bad_shift
         $error("modtmr_ctl: MAX_SHIFT must lie in 1..7");
      end
   endgenerate

   logic flag_w, ie_w, halt_w, clr_w, tick_w, wrap_w;
   logic [2:0] sel_w;
   logic [CNT_W-1:0] cnt_w, mod_w;
   logic [WIDE-1:0] cnt_x, mod_x;

   modtmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk_i(clk_i), .rst_i(rst_i), .addr_i(bus_addr_i), .rd_i(bus_rd_i),
      .wr_i(bus_wr_i), .wdata_i(bus_wdata_i), .wrap_i(wrap_w),
      .flag_o(flag_w), .ie_o(ie_w), .halt_o(halt_w), .sel_o(sel_w),
      .clr_o(clr_w), .mod_o(mod_w)
   );

   modtmr_presc #(.MAX_SHIFT(MAX_SHIFT)) u_presc (
      .clk_i(clk_i), .rst_i(rst_i), .run_i(!halt_w), .clr_i(clr_w),
      .sel_i(sel_w), .tick_o(tick_w)
   );

   modtmr_count #(.CNT_W(CNT_W)) u_count (
      .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_w), .clr_i(clr_w),
      .mod_i(mod_w), .cnt_o(cnt_w), .wrap_o(wrap_w)
   );

   assign cnt_x = WIDE'(cnt_w);
   assign mod_x = WIDE'(mod_w);

   always_comb begin
      case (bus_addr_i)
         A_CTRL:  bus_rdata_o = {flag_w, ie_w, halt_w, 2'b00, sel_w};
         A_MODLO: bus_rdata_o = mod_x[DATA_W-1:0];
         A_MODHI: bus_rdata_o = mod_x[WIDE-1:DATA_W];
         A_CNTLO: bus_rdata_o = cnt_x[DATA_W-1:0];
         A_CNTHI: bus_rdata_o = cnt_x[WIDE-1:DATA_W];
         default: bus_rdata_o = '0;
      endcase
   end

   assign irq_o         = flag_w && ie_w;
   assign cap_inhibit_o = halt_w;
   assign count_o       = cnt_w;
   assign modulo_o      = mod_w;
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
   import modtmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [2:0]       bus_addr_i,
   input logic             bus_wr_i,
   input logic [7:0]       bus_wdata_i,
   input logic             cap_inhibit_o,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] modulo_o,
   input logic             flag_w
);
   logic clr_wr;
   assign clr_wr = bus_wr_i && (bus_addr_i == A_CTRL) && bus_wdata_i[B_CLR];

   // R9
   halt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(cap_inhibit_o) && !$past(clr_wr) |-> count_o == $past(count_o));

   // R4
   wrap_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(count_o) == $past(modulo_o)) && (count_o != $past(count_o)) |-> count_o == '0);

   // R4
   flag_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(flag_w) |-> count_o == '0);

   // R5
   flag_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(flag_w) |-> $past(bus_wr_i && (bus_addr_i == A_CTRL) && !bus_wdata_i[B_FLAG]));

   // R10
   clr_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(clr_wr) |-> count_o == '0);
endmodule

bind modtmr_ctl modtmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
   .bus_wdata_i(bus_wdata_i), .cap_inhibit_o(cap_inhibit_o), .count_o(count_o),
   .modulo_o(modulo_o), .flag_w(flag_w)
);

// File: tb/sim_modtmr_ctl.sv
`timescale 1ns/1ps
module sim_modtmr_ctl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  addr = 3'd0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic        irq, capinh;
   logic [15:0] cnt, modv;
   int          n_run = 0;
   int          n_fail = 0;
   logic [7:0]  d;

   always #5 clk = ~clk;

   modtmr_ctl u0 (
      .clk_i(clk), .rst_i(rst), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .cap_inhibit_o(capinh),
      .count_o(cnt), .modulo_o(modv)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wreg(input logic [2:0] a, input logic [7:0] v);
      addr = a; wdata = v; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; addr = 3'd0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [7:0] v);
      addr = a; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0; addr = 3'd0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      addr = a;
      #1 v = rdata;
      addr = 3'd0;
   endtask

   task automatic step(input int k);
      repeat (k) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst = 1'b0;
      // R1 reset state
      peek(3'd0, d); chk("R1 ctrl", d, 8'h20);
      chk("R1 count", cnt, 0);
      chk("R1 modulo", modv, 16'hFFFF);
      chk("R1 irq", irq, 0);
      chk("R1 capinh", capinh, 1);
      step(5);
      chk("R9 halted after reset", cnt, 0);

      // R11 modulo bytes
      wreg(3'd1, 8'h34); wreg(3'd2, 8'h12);
      chk("R11 modulo_o", modv, 16'h1234);
      rreg(3'd1, d); chk("R11 lo", d, 8'h34);
      rreg(3'd2, d); chk("R11 hi", d, 8'h12);

      // R3 R4 R5 sweep over modulo and prescaler select
      wreg(3'd2, 8'h00);
      for (int m = 0; m < 4; m++) begin
         wreg(3'd1, 8'(m));
         for (int s = 0; s < 8; s++) begin
            int dv;
            dv = 1 << ((s > 6) ? 6 : s);
            wreg(3'd0, 8'h20);
            rreg(3'd0, d);
            wreg(3'd0, 8'h10 | 8'(s));
            for (int t = 0; t <= (m + 1) * dv * 2 + 1; t++) begin
               chk("R3 count", cnt, ((t / dv) % (m + 1)));
               peek(3'd0, d);
               chk("R4 flag", d[7], ((t / dv) >= (m + 1)) ? 1 : 0);
               chk("R8 irq off", irq, 0);
               @(negedge clk);
            end
         end
      end

      // R9 halt and resume
      wreg(3'd1, 8'd200);
      wreg(3'd0, 8'h10);
      step(5);
      chk("R9 running", cnt, 5);
      wreg(3'd0, 8'h20);
      chk("R9 last tick", cnt, 6);
      step(10);
      chk("R9 held", cnt, 6);
      chk("R9 capinh", capinh, 1);
      peek(3'd3, d); chk("R11 count lo", d, 8'd6);
      wreg(3'd0, 8'h00);
      chk("R9 resume edge", cnt, 6);
      chk("R9 capinh off", capinh, 0);
      step(3);
      chk("R9 resumed", cnt, 9);

      // R5 R6 interlock, modulo 3, select 0
      wreg(3'd1, 8'd3);
      wreg(3'd0, 8'h20);
      rreg(3'd0, d);
      wreg(3'd0, 8'h10);
      step(3);
      peek(3'd0, d); chk("R4 no flag yet", d[7], 0);
      step(1);
      peek(3'd0, d); chk("R4 flag at wrap", d[7], 1);
      rreg(3'd0, d);
      step(3);
      wreg(3'd0, 8'h00);
      peek(3'd0, d); chk("R6 clear cancelled", d[7], 1);
      rreg(3'd0, d);
      wreg(3'd0, 8'h00);
      peek(3'd0, d); chk("R5 cleared", d[7], 0);
      step(1);
      peek(3'd0, d); chk("R4 set again", d[7], 1);
      wreg(3'd0, 8'h00);
      peek(3'd0, d); chk("R5 write without read", d[7], 1);

      // R7 R2
      wreg(3'd0, 8'h20);
      rreg(3'd0, d);
      wreg(3'd0, 8'h20);
      peek(3'd0, d); chk("R5 cleared halted", d, 8'h20);
      wreg(3'd0, 8'hA0);
      peek(3'd0, d); chk("R7 write one", d, 8'h20);
      wreg(3'd0, 8'h28);
      peek(3'd0, d); chk("R2 reserved bit", d, 8'h20);

      // R8 irq
      wreg(3'd0, 8'h60);
      chk("R8 ie no flag", irq, 0);
      wreg(3'd0, 8'h50);
      step(3);
      chk("R8 before wrap", irq, 0);
      step(1);
      chk("R8 flag and ie", irq, 1);
      wreg(3'd0, 8'h00);
      chk("R8 ie off", irq, 0);
      peek(3'd0, d); chk("R8 flag kept", d[7], 1);

      // R10 counter clear
      step(2);
      wreg(3'd0, 8'h55);
      peek(3'd0, d); chk("R10 other bits", d & 8'h7F, 8'h45);
      chk("R10 count cleared", cnt, 0);
      step(31);
      chk("R10 phase cleared before", cnt, 0);
      step(1);
      chk("R10 phase cleared after", cnt, 1);
      wreg(3'd0, 8'h30);
      chk("R10 clear while halted", cnt, 0);
      chk("R10 halt kept", capinh, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule